// File: doc/BRIEF.md
# Cumulative Thermal Throttle Timer

This block measures how long an active-low thermal throttle input has been held low in total, summed over any number of separate assertions. Time is measured in units derived from a periodic timebase tick. A sub-counter keeps the part of a unit that has not been completed yet, so short assertions still add up. The result is an 8-bit value, and a read strobe clears it.

The value has a special form near zero. As soon as an assertion is seen after a clear, the value shows 1. It keeps showing 1 until two whole units have built up. After that it shows the true number of units. The count stops at full scale and stays there until it is read. The block also compares the value with a programmable limit. When the value is above the limit, it sets a sticky flag that alert logic can use, and software clears the flag.

A four-state machine controls the accumulation:
- IDLE: nothing has been seen since the last clear.
- ACTIVE: the input is asserted and time is counting.
- PAUSED: the input is released and the total is held.
- FULL: the count is saturated.

The transitions are:
- IDLE→ACTIVE and PAUSED→ACTIVE when the input is asserted.
- ACTIVE→PAUSED when the input is released.
- Any counting state→FULL when the last unit is reached.
- Any state→IDLE when a read happens while the input is released.
- Any state→ACTIVE when a read happens while the input is asserted.

Top module: `therm_accum_timer`

## Requirements
- R1: After reset, `timer_val` is 0x00 and `over_flag` is 0.
- R2: Time builds up only while the synchronised input is low. While the input is high, `timer_val` and the sub-unit remainder are both held, so partial units from separate assertions add together.
- R3: When the unit count reaches 255, `timer_val` stays at 0xFF until a read, whatever the later ticks and input levels are.
- R4: On the first assertion after a clear, `timer_val` becomes 0x01. It stays 0x01 while fewer than two whole units have built up.
- R5: Once two or more units have built up, `timer_val` equals the number of units. One unit is `SUB_TICKS` asserted ticks (4 by default), so 20 asserted ticks read as 0x05.
- R6: A read strobe taken while the input is high makes `timer_val` 0x00 on the next cycle.
- R7: A read strobe taken while the input is low makes `timer_val` 0x01 on the next cycle. Accumulation then restarts with the remainder at zero.
- R8: `over_flag` sets when `timer_val` is greater than `limit`. It stays set until `flag_clr`. When clear and set happen in the same cycle, the set wins.
- R9: With `limit` = 0x00, any assertion sets `over_flag`, including an assertion still in progress when a read happens.
- R10: `therm_n` passes through a two-flop synchroniser. A falling edge on the pin changes `timer_val` after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_n | input | 1 | Asynchronous active-low throttle input |
| tick | input | 1 | One-cycle timebase pulse; `SUB_TICKS` pulses make one unit |
| rd_stb | input | 1 | Read strobe for the timer value; clears it |
| flag_clr | input | 1 | Clears the sticky limit flag |
| limit | input | 8 | Limit compared against the timer value |
| timer_val | output | 8 | Current timer value |
| over_flag | output | 1 | Sticky flag: the timer value went above the limit |

## Verification
Two cases are hard to reach from the ports. The first is the saturated state, which needs more than a thousand asserted ticks. The stimulus reaches it by holding the input low and pulsing the tick on every cycle, then checks that the value holds. The second is a read landing partway through an assertion that already carries a partial unit. The stimulus leaves two leftover ticks before the read. It then counts exactly enough ticks afterwards that a remainder kept by mistake would show up as an early step from 1 to 2. The order of a flag clear against a set condition is forced by pulsing `flag_clr` in the cycle just after a mid-assertion read.

// File: rtl/therm_timer_pkg.sv
package therm_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_PAUSED = 2'd2,
        ST_FULL   = 2'd3
    } acc_state_t;
endpackage

// File: rtl/therm_sync2.sv
module therm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q, sync_q;

    // Both flops reset high: the pin idles high when released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/therm_accum_fsm.sv
module therm_accum_fsm
    import therm_timer_pkg::*;
#(
    parameter int TW        = 8,
    parameter int SUB_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    input  logic          tick,
    input  logic          rd_stb,
    output logic [TW-1:0] timer_val
);
    localparam int SUB_W = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_TICKS - 1);
    localparam logic [TW-1:0]    U_MAX    = {TW{1'b1}};
    localparam logic [TW-1:0]    U_ONE    = TW'(1);

    acc_state_t        st_q, st_d;
    logic [TW-1:0]     units_q;
    logic [SUB_W-1:0]  sub_q;
    logic              cnt_en, unit_done, sat_hit;

    assign cnt_en    = lvl && (st_q != ST_FULL) && !rd_stb;
    assign unit_done = cnt_en && tick && (sub_q == SUB_LAST);
    assign sat_hit   = unit_done && (units_q == U_MAX - U_ONE);

    // Next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (lvl) st_d = sat_hit ? ST_FULL : ST_ACTIVE;
            ST_ACTIVE: if (sat_hit) st_d = ST_FULL;
                       else if (!lvl) st_d = ST_PAUSED;
            ST_PAUSED: if (lvl) st_d = sat_hit ? ST_FULL : ST_ACTIVE;
            ST_FULL:   st_d = ST_FULL;
        endcase
        if (rd_stb) st_d = lvl ? ST_ACTIVE : ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Unit and remainder counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units_q <= '0;
            sub_q   <= '0;
        end else if (rd_stb) begin
            units_q <= '0;
            sub_q   <= '0;
        end else if (cnt_en && tick) begin
            if (sub_q == SUB_LAST) begin
                sub_q   <= '0;
                units_q <= units_q + U_ONE;
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end

    // Output decode: preset 1 until two units exist
    always_comb begin
        unique case (st_q)
            ST_IDLE: timer_val = '0;
            ST_FULL: timer_val = U_MAX;
            default: timer_val = (units_q == '0) ? U_ONE : units_q;
        endcase
    end
endmodule

// File: rtl/therm_limit_flag.sv
module therm_limit_flag #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] limit,
    input  logic          flag_clr,
    output logic          over_flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (timer_val > limit) || (flag_q && !flag_clr);
    end

    assign over_flag = flag_q;
endmodule

// File: rtl/therm_accum_timer.sv
module therm_accum_timer #(
    parameter int TW        = 8,
    parameter int SUB_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          therm_n,
    input  logic          tick,
    input  logic          rd_stb,
    input  logic          flag_clr,
    input  logic [TW-1:0] limit,
    output logic [TW-1:0] timer_val,
    output logic          over_flag
);
    logic therm_n_s;
    logic therm_lvl;

    therm_sync2 u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (therm_n),
        .dout (therm_n_s)
    );

    assign therm_lvl = !therm_n_s;

    therm_accum_fsm #(.TW(TW), .SUB_TICKS(SUB_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (therm_lvl),
        .tick     (tick),
        .rd_stb   (rd_stb),
        .timer_val(timer_val)
    );

    therm_limit_flag #(.TW(TW)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .timer_val(timer_val),
        .limit    (limit),
        .flag_clr (flag_clr),
        .over_flag(over_flag)
    );
endmodule

// File: rtl/therm_accum_timer_chk.sv
module therm_accum_timer_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lvl,
    input logic          rd_stb,
    input logic          flag_clr,
    input logic [TW-1:0] timer_val,
    input logic          over_flag
);
    a_r2_hold_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !rd_stb) |=> $stable(timer_val));

    a_r3_saturated_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_val == {TW{1'b1}} && !rd_stb) |=> (timer_val == {TW{1'b1}}));

    a_r4_first_assert_one: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_val == '0 && lvl && !rd_stb) |=> (timer_val == TW'(1)));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !lvl) |=> (timer_val == '0));

    a_r7_read_mid_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && lvl) |=> (timer_val == TW'(1)));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (over_flag && !flag_clr) |=> over_flag);
endmodule

bind therm_accum_timer therm_accum_timer_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (therm_lvl),
    .rd_stb   (rd_stb),
    .flag_clr (flag_clr),
    .timer_val(timer_val),
    .over_flag(over_flag)
);

// File: tb/therm_accum_timer_tb_top.sv
`timescale 1ns/1ps
module therm_accum_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       therm_n = 1'b1;
    logic       tick = 1'b0;
    logic       rd_stb = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] limit = 8'hFF;
    logic [7:0] timer_val;
    logic       over_flag;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    therm_accum_timer dut_i (
        .clk(clk), .rst_n(rst_n), .therm_n(therm_n), .tick(tick),
        .rd_stb(rd_stb), .flag_clr(flag_clr), .limit(limit),
        .timer_val(timer_val), .over_flag(over_flag)
    );

    // {pin level, tick count, expected value}; SUB_TICKS = 4
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'd0,  8'd1},   // R4 first assertion
        {1'b0, 8'd4,  8'd1},   // R4 one unit still reads 1
        {1'b1, 8'd8,  8'd1},   // R2 released: ticks ignored
        {1'b0, 8'd4,  8'd2},   // R5 two units
        {1'b1, 8'd0,  8'd2},   // R2 hold
        {1'b0, 8'd14, 8'd5},   // R5 five units, remainder 2
        {1'b1, 8'd3,  8'd5},   // R2 remainder kept
        {1'b0, 8'd2,  8'd6}    // R2 remainder joins
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input logic v);
        therm_n = v;
        cyc(4);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            cyc(n);
            tick = 1'b0;
        end
        cyc(2);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    initial begin
        cyc(3);
        @(negedge clk);
        chk("R1 timer", timer_val, 8'h00);
        chk("R1 flag", {7'd0, over_flag}, 8'h00);
        rst_n = 1'b1;
        cyc(2);

        // R10: synchroniser latency
        therm_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 not before third edge", timer_val, 8'h00);
        @(negedge clk);
        chk("R10 after third edge", timer_val, 8'h01);
        cyc(2);

        for (int i = 0; i < 8; i++) begin
            set_pin(VEC[i][16]);
            ticks(int'(VEC[i][15:8]));
            @(negedge clk);
            chk($sformatf("R2/R4/R5 vec%0d", i), timer_val, VEC[i][7:0]);
            #1;
        end

        // R6: read while released
        set_pin(1'b1);
        pulse_rd();
        @(negedge clk);
        chk("R6 read clears", timer_val, 8'h00);

        // R3: saturation
        set_pin(1'b0);
        ticks(1100);
        @(negedge clk);
        chk("R3 saturated", timer_val, 8'hFF);
        set_pin(1'b1);
        ticks(20);
        set_pin(1'b0);
        ticks(20);
        @(negedge clk);
        chk("R3 stays full", timer_val, 8'hFF);

        // R7: read mid-assertion with partial unit pending
        set_pin(1'b1); pulse_rd();
        set_pin(1'b0);
        ticks(6);
        pulse_rd();
        @(negedge clk);
        chk("R7 read mid-assert", timer_val, 8'h01);
        #1;
        ticks(6);
        @(negedge clk);
        chk("R7 remainder restarted", timer_val, 8'h01);
        #1;
        ticks(2);
        @(negedge clk);
        chk("R7 two units", timer_val, 8'h02);
        #1;

        // R8: threshold and stickiness
        set_pin(1'b1); pulse_rd();
        limit = 8'd3;
        pulse_clr(); cyc(1);
        set_pin(1'b0);
        ticks(12);
        @(negedge clk);
        chk("R8 at limit no flag", {7'd0, over_flag}, 8'h00);
        #1;
        ticks(4);
        @(negedge clk);
        chk("R8 above limit", {7'd0, over_flag}, 8'h01);
        #1;
        set_pin(1'b1); pulse_rd(); cyc(2);
        @(negedge clk);
        chk("R8 sticky after clear of timer", {7'd0, over_flag}, 8'h01);
        #1;
        pulse_clr(); cyc(1);
        @(negedge clk);
        chk("R8 cleared", {7'd0, over_flag}, 8'h00);
        #1;

        // R9: zero limit
        limit = 8'd0;
        set_pin(1'b0);
        @(negedge clk);
        chk("R9 any assertion", {7'd0, over_flag}, 8'h01);
        #1;
        pulse_rd();
        pulse_clr();
        cyc(1);
        @(negedge clk);
        chk("R9 mid-read sets, beats clear (R8)", {7'd0, over_flag}, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule